// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column addresses of one memory burst, one address per enabled clock. A controller pulses `start` with the first column, a length code and an ordering bit. From the next cycle the sequencer offers one beat per cycle in which `enable` is high, with the column of that beat. It raises `lastBeat` on the beat that closes the burst, then falls idle.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the naturally aligned block that holds the starting column. Within that block they run in one of two orders: incrementing with wrap-around, or the exclusive-OR of the start column with the beat index. A page-length burst walks every column of the row upward from the start column and wraps at the row end. It runs until `burstStop` ends it. `burstStop` can also cut a fixed-length burst short.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, `beatValid` and `lastBeat` are 0 and the sequencer is idle.
- R2: A `start` pulse while idle captures `startCol`, `lenSel` and `burstType`. No beat is offered in the start cycle. Beat 0 is offered from the next cycle, and its column equals `startCol`.
- R3: `lenSel` codes: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 7 gives a page burst. The codes 4, 5 and 6 behave as 1 beat.
- R4: Sequential order (`burstType`=0) with length BL: beat k has column `(startCol & ~(BL-1)) | ((startCol + k) mod BL)`.
- R5: Interleaved order (`burstType`=1) with length BL: beat k has column `startCol ^ k`.
- R6: A page burst gives beat k the column `(startCol + k) mod 2^COL_W`, whatever `burstType` is. It raises `lastBeat` only when stopped.
- R7: `lastBeat` is 1 on beat BL-1 of a fixed burst. `beatValid` is 0 in the following cycle unless a new `start` was accepted there.
- R8: `burstStop` high during a valid beat makes that beat the last one (`lastBeat`=1), and the sequencer is idle in the next cycle. `burstStop` while idle, or while `enable` is low, has no effect.
- R9: While a burst is active and `enable` is low, `beatValid` is 0 and the beat index does not advance. The column resumes unchanged when `enable` returns.
- R10: A `start` pulse during an active burst is ignored. The running burst keeps its columns and its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a burst (taken only while idle) |
| startCol | input | COL_W | First column of the burst |
| lenSel | input | 3 | Burst length code |
| burstType | input | 1 | 0 sequential, 1 interleaved |
| burstStop | input | 1 | End the burst at the current beat |
| enable | input | 1 | Allow a beat this cycle |
| col | output | COL_W | Column of the current beat |
| beatValid | output | 1 | A beat is offered this cycle |
| lastBeat | output | 1 | The current beat is the final one |

## Verification
The bench sweeps every start column for each fixed length in both orders. This catches a wrap that carries into the upper column bits, and an XOR or wrap applied to the wrong number of low bits. A design that misaligned the block would show a wrong column on the first wrapped beat. Page bursts are run past the row end and stopped late, so a design that ended them at a fixed count or ignored the row wrap is caught. Further cases cover a stop while idle or while `enable` is low, a second `start` during a burst, and enable gaps. These expose a design that terminates on a stop it should ignore, reloads during a burst, or advances the index without granting a beat.

// File: rtl/burst_col_seq_pkg.sv
package burst_col_seq_pkg;

  typedef enum logic [2:0] {
    LEN_ONE  = 3'd0,
    LEN_TWO  = 3'd1,
    LEN_FOUR = 3'd2,
    LEN_EIGHT = 3'd3,
    LEN_PAGE = 3'd7
  } lenCode_e;

  typedef struct packed {
    logic load;
    logic step;
  } seqStrobe_t;

endpackage

// File: rtl/burst_col_seq_ctrl.sv
module burst_col_seq_ctrl
  import burst_col_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       enable,
  input  logic       burstStop,
  input  logic       isFinal,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       beatValid,
  output logic       lastBeat
);

  logic activeQ;
  logic finishing;

  assign strobe.load = start && !activeQ;
  assign strobe.step = activeQ && enable;
  assign finishing   = strobe.step && (burstStop || isFinal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeQ <= 1'b0;
    end else if (strobe.load) begin
      activeQ <= 1'b1;
    end else if (finishing) begin
      activeQ <= 1'b0;
    end
  end

  assign busy      = activeQ;
  assign beatValid = strobe.step;
  assign lastBeat  = finishing;

endmodule

// File: rtl/burst_col_seq_dp.sv
module burst_col_seq_dp
  import burst_col_seq_pkg::*;
#(
  parameter int COL_W = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenSel,
  input  logic             burstType,
  output logic [COL_W-1:0] col,
  output logic             isFinal
);

  logic [COL_W-1:0] baseQ;
  logic [COL_W-1:0] beatQ;
  logic [2:0]       lenQ;
  logic             typeQ;
  logic [COL_W-1:0] wrapMask;
  logic             pageMode;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] xorCol;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      beatQ <= '0;
      lenQ  <= 3'd0;
      typeQ <= 1'b0;
    end else if (strobe.load) begin
      baseQ <= startCol;
      beatQ <= '0;
      lenQ  <= lenSel;
      typeQ <= burstType;
    end else if (strobe.step) begin
      beatQ <= beatQ + COL_W'(1);
    end
  end

  always_comb begin
    case (lenQ)
      LEN_TWO:   wrapMask = COL_W'(1);
      LEN_FOUR:  wrapMask = COL_W'(3);
      LEN_EIGHT: wrapMask = COL_W'(7);
      LEN_PAGE:  wrapMask = '1;
      default:   wrapMask = '0;
    endcase
  end

  assign pageMode = (lenQ == LEN_PAGE);
  assign seqCol   = (baseQ & ~wrapMask) | ((baseQ + beatQ) & wrapMask);
  assign xorCol   = baseQ ^ (beatQ & wrapMask);
  assign col      = (typeQ && !pageMode) ? xorCol : seqCol;
  assign isFinal  = !pageMode && ((beatQ & wrapMask) == wrapMask);

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import burst_col_seq_pkg::*;
#(
  parameter int COL_W = 8
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [COL_W-1:0] startCol,
  input  logic [2:0]       lenSel,
  input  logic             burstType,
  input  logic             burstStop,
  input  logic             enable,
  output logic [COL_W-1:0] col,
  output logic             beatValid,
  output logic             lastBeat
);

  seqStrobe_t strobe;
  logic       isFinal;
  logic       busy;

  burst_col_seq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .enable    (enable),
    .burstStop (burstStop),
    .isFinal   (isFinal),
    .strobe    (strobe),
    .busy      (busy),
    .beatValid (beatValid),
    .lastBeat  (lastBeat)
  );

  burst_col_seq_dp #(.COL_W(COL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .startCol  (startCol),
    .lenSel    (lenSel),
    .burstType (burstType),
    .col       (col),
    .isFinal   (isFinal)
  );

endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 8
)(
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             enable,
  input logic             burstStop,
  input logic             busy,
  input logic [COL_W-1:0] col,
  input logic             beatValid,
  input logic             lastBeat
);

  // R2: an idle start launches a burst
  a_r2_start_launches: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R7: the sequencer is idle after a final beat
  a_r7_idle_after_last: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |=> !busy);

  // R8: a stop during a beat closes it
  a_r8_stop_closes: assert property (@(posedge clk) disable iff (!rstN)
    (beatValid && burstStop) |-> lastBeat);

  // R9: no beat without enable
  a_r9_no_beat_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !beatValid);

  // R9: column holds across a disabled cycle of an active burst
  a_r9_hold_col: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !enable) |=> $stable(col));

  // R7: a last beat is always a valid beat
  a_r7_last_is_beat: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid);

endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .start     (start),
  .enable    (enable),
  .burstStop (burstStop),
  .busy      (busy),
  .col       (col),
  .beatValid (beatValid),
  .lastBeat  (lastBeat)
);

// File: tb/burst_col_seq_bench.sv
`timescale 1ns/1ps
module burst_col_seq_bench;
  localparam int COL_W = 8;
  localparam int ROW = 1 << COL_W;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             start = 1'b0;
  logic [COL_W-1:0] startCol = '0;
  logic [2:0]       lenSel = 3'd0;
  logic             burstType = 1'b0;
  logic             burstStop = 1'b0;
  logic             enable = 1'b0;
  logic [COL_W-1:0] col;
  logic             beatValid;
  logic             lastBeat;

  int  total = 0;
  int  bad = 0;
  bit  finished = 1'b0;

  always #2.5 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) u_burst_col_seq (
    .clk(clk), .rstN(rstN), .start(start), .startCol(startCol),
    .lenSel(lenSel), .burstType(burstType), .burstStop(burstStop),
    .enable(enable), .col(col), .beatValid(beatValid), .lastBeat(lastBeat)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lenOf(int code);
    if (code <= 3) return 1 << code;
    if (code == 7) return ROW;
    return 1;
  endfunction

  function automatic int expCol(int s, int code, int t, int k);
    int bl = lenOf(code);
    int m;
    if (bl == ROW) return (s + k) % ROW;
    m = bl - 1;
    if (t != 0) return s ^ (k & m);
    return (s & ~m & (ROW - 1)) | ((s + k) & m);
  endfunction

  // launch a burst and check every beat; stopAt < 0 means run to natural end
  task automatic runBurst(string req, int s, int code, int t, int nBeats, int stopAt);
    @(negedge clk);
    start = 1'b1; startCol = COL_W'(s); lenSel = 3'(code);
    burstType = t[0]; enable = 1'b1; burstStop = 1'b0;
    #1 chk("R2", "valid in start cycle", int'(beatValid), 0);
    for (int k = 0; k < nBeats; k++) begin
      @(negedge clk);
      start = 1'b0;
      burstStop = (k == stopAt);
      #1;
      chk(req, "valid", int'(beatValid), 1);
      chk(req, "col", int'(col), expCol(s, code, t, k));
      chk((stopAt >= 0) ? "R8" : "R7", "last", int'(lastBeat), int'(k == nBeats - 1));
    end
    @(negedge clk);
    burstStop = 1'b0;
    #1 chk((stopAt >= 0) ? "R8" : "R7", "valid after end", int'(beatValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "valid in reset", int'(beatValid), 0);
    chk("R1", "last in reset", int'(lastBeat), 0);
    rstN = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    #1 chk("R1", "valid after reset", int'(beatValid), 0);

    // R4 / R5 sweep over all start columns and fixed lengths
    for (int code = 0; code < 4; code++)
      for (int t = 0; t < 2; t++)
        for (int s = 0; s < ROW; s++)
          runBurst(t ? "R5" : "R4", s, code, t, lenOf(code), -1);

    // R3: reserved codes act as single-beat bursts
    for (int code = 4; code < 7; code++)
      for (int s = 0; s < ROW; s += 37)
        runBurst("R3", s, code, code & 1, 1, -1);

    // R6: page bursts in both type settings, past the row end, then stopped
    runBurst("R6", 250, 7, 0, 300, 299);
    runBurst("R6", 3, 7, 1, 260, 259);
    runBurst("R6", 0, 7, 0, 1, 0);

    // R8: stop cuts a fixed burst short
    runBurst("R8", 8'h4d, 3, 1, 3, 2);
    runBurst("R8", 8'h16, 2, 0, 2, 1);

    // R8: stop while idle has no effect
    @(negedge clk);
    burstStop = 1'b1;
    #1;
    chk("R8", "valid idle stop", int'(beatValid), 0);
    chk("R8", "last idle stop", int'(lastBeat), 0);
    @(negedge clk);
    burstStop = 1'b0;
    runBurst("R8", 8'h81, 1, 0, 2, -1);

    // R9: enable gaps, with a stop during a gap that must be ignored (R8)
    begin
      int s = 8'h35;
      @(negedge clk);
      start = 1'b1; startCol = COL_W'(s); lenSel = 3'd3; burstType = 1'b0; enable = 1'b1;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        start = 1'b0;
        if (k == 3) begin
          for (int g = 0; g < 3; g++) begin
            enable = 1'b0;
            burstStop = (g == 1);
            #1;
            chk("R9", "valid in gap", int'(beatValid), 0);
            chk("R8", "last in gap", int'(lastBeat), 0);
            @(negedge clk);
          end
          enable = 1'b1;
          burstStop = 1'b0;
        end
        #1;
        chk("R9", "valid", int'(beatValid), 1);
        chk("R9", "col", int'(col), expCol(s, 3, 0, k));
        chk("R9", "last", int'(lastBeat), int'(k == 7));
      end
      @(negedge clk);
      #1 chk("R9", "valid after end", int'(beatValid), 0);
    end

    // R10: start during a burst is ignored
    begin
      int s = 8'h22;
      @(negedge clk);
      start = 1'b1; startCol = COL_W'(s); lenSel = 3'd2; burstType = 1'b1; enable = 1'b1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        start = (k == 1);
        startCol = (k == 1) ? 8'h99 : COL_W'(s);
        lenSel = (k == 1) ? 3'd7 : 3'd2;
        burstType = (k == 1) ? 1'b0 : 1'b1;
        #1;
        chk("R10", "valid", int'(beatValid), 1);
        chk("R10", "col", int'(col), expCol(s, 2, 1, k));
        chk("R10", "last", int'(lastBeat), int'(k == 3));
      end
      @(negedge clk);
      start = 1'b0;
      #1 chk("R10", "valid after end", int'(beatValid), 0);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule